// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block keeps the active-interrupt bookkeeping for one processor. It holds the ID of the interrupt now being serviced and that interrupt's priority. It also keeps a chain of the interrupts that it preempted. An acknowledge strobe takes the currently selected pending interrupt if that interrupt outranks the running one. Otherwise the acknowledge returns the spurious ID 1023. A completion strobe retires an interrupt. Completions may arrive in any order.

Each implemented interrupt owns one link entry. The link entry holds the ID that was running when that interrupt was accepted. Retiring the running interrupt pops the chain. Retiring an interrupt deeper in the chain starts a walk that moves one link per clock. The walk finds the entry that points at the retired ID and bypasses it. During the walk the block raises `busy` and ignores all strobes.

The block also emits one-cycle requests that tell the pending logic to clear the bit of an accepted interrupt. It emits a second kind of request to set the bit again for a level-sensitive source that is still asserted at completion. Choosing the highest pending interrupt happens elsewhere; the chosen ID arrives on `pendId`.

Top module: `irq_track_top`

## Requirements
- R1: After reset, `runId` is 1023, `runPrio` is 0x100 and `busy` is 0. `ackValid`, `clrPendValid` and `setPendValid` are 0, and every link entry holds 1023.
- R2: Consider an acknowledge taken while not busy, with `pendId` below NUM_IRQ and priority P strictly below `runPrio`. One cycle later it gives `ackValid`=1 and `ackId`=`pendId`, plus a `clrPendValid` pulse with `clrPendId`=`pendId`. From then on `runId`=`pendId`. The previous `runId` is stored as the link entry of the new interrupt.
- R3: An acknowledge returns `ackId`=1023, with `ackValid`=1 and no `clrPendValid`, when `pendId` is 1023, or is at or above NUM_IRQ, or has a priority not strictly below `runPrio`. The running state is left unchanged.
- R4: `runPrio` is 0x100 whenever `runId` is 1023. Otherwise `runPrio` is the 8-bit priority (a lower value is more urgent) that the running interrupt had in `prioTable` (bits `8*id+7:8*id`) when it became running.
- R5: A completion whose `eoiId` is at or above NUM_IRQ, including 1023, has no effect.
- R6: A completion while `runId` is 1023 has no effect.
- R7: Completing the running interrupt sets `runId` to its link entry one cycle later. `runPrio` then takes that entry's priority, or 0x100 for 1023, and `busy` stays 0.
- R8: Completing a non-running interrupt raises `busy` for one cycle per chain entry examined, starting from the running interrupt. The walk stops at an entry whose link is 1023, or at an entry whose link is the completed ID. In the second case that entry takes the link of the completed ID. `runId` does not change.
- R9: An accepted completion (not dropped by R5 or R6) pulses `setPendValid` one cycle later with `setPendId`=`eoiId` when all four of these hold for that ID: `edgeCfg` is 0 (level-sensitive), `enableVec` is 1, `levelVec` is 1 and `targetVec` is 1.
- R10: While `busy` is 1, acknowledge and completion strobes are ignored.
- R11: When acknowledge and completion strobes arrive in the same cycle, only the acknowledge is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ackReq | input | 1 | Acknowledge strobe |
| eoiReq | input | 1 | Completion strobe |
| eoiId | input | 10 | ID being completed |
| pendId | input | 10 | Highest pending ID from the selection logic (1023 = none) |
| prioTable | input | NUM_IRQ*8 | Priority of each interrupt, 8 bits per ID |
| edgeCfg | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| enableVec | input | NUM_IRQ | Per-interrupt enable |
| levelVec | input | NUM_IRQ | Current input level per interrupt |
| targetVec | input | NUM_IRQ | Interrupt routed to this processor |
| ackId | output | 10 | Result of the last acknowledge |
| ackValid | output | 1 | One-cycle pulse: `ackId` is new |
| runId | output | 10 | Running interrupt (1023 = none) |
| runPrio | output | 9 | Running priority (0x100 = idle) |
| clrPendValid | output | 1 | Request to clear a pending bit |
| clrPendId | output | 10 | ID whose pending bit is cleared |
| setPendValid | output | 1 | Request to set a pending bit again |
| setPendId | output | 10 | ID whose pending bit is set |
| busy | output | 1 | Chain walk in progress |

## Verification
All results are registered. The effects of a strobe sampled at one rising edge appear at the next edge: `ackValid`/`ackId`, `clrPendValid`, `setPendValid`, the new `runId` and `runPrio`, and the rise of `busy`. A walk of k examined entries holds `busy` high for exactly k cycles after that first edge. The bench drives inputs on falling edges. A behavioural model advances on each rising edge. Every output is compared against it at the following falling edge, so the checks land one cycle after the strobe. Directed checks use the same spacing and wait out the walk cycles before expecting `busy` to drop.

// File: rtl/irq_track_pkg.sv
package irq_track_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'h3FF;

  typedef enum logic {ST_IDLE, ST_WALK} trk_state_e;

  typedef struct packed {
    logic ackTake;
    logic ackSpur;
    logic eoiTop;
    logic walkStart;
    logic walkAdvance;
    logic walkSplice;
    logic repend;
  } trk_cmd_t;
endpackage

// File: rtl/irq_track_ctrl.sv
module irq_track_ctrl
  import irq_track_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ackReq,
  input  logic                eoiReq,
  input  logic [ID_W-1:0]     eoiId,
  input  logic [ID_W-1:0]     pendId,
  input  logic [ID_W-1:0]     runId,
  input  logic [PRIO_W:0]     runPrio,
  input  logic [PRIO_W:0]     pendPrio,
  input  logic [ID_W-1:0]     walkLink,
  input  logic [ID_W-1:0]     walkTgt,
  input  logic [NUM_IRQ-1:0]  edgeCfg,
  input  logic [NUM_IRQ-1:0]  enableVec,
  input  logic [NUM_IRQ-1:0]  levelVec,
  input  logic [NUM_IRQ-1:0]  targetVec,
  output trk_cmd_t            cmd,
  output logic                busy
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [ID_W-1:0]  NUM_ID   = ID_W'(NUM_IRQ);
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(NUM_IRQ - 1);

  trk_state_e state;
  logic [IDX_W-1:0] stepCnt;
  logic [IDX_W-1:0] eoiIdx;
  logic pendInRange, eoiInRange, stillRaised;

  assign eoiIdx      = eoiId[IDX_W-1:0];
  assign pendInRange = pendId < NUM_ID;
  assign eoiInRange  = eoiId < NUM_ID;
  assign stillRaised = !edgeCfg[eoiIdx] && enableVec[eoiIdx] &&
                       levelVec[eoiIdx] && targetVec[eoiIdx];
  assign busy = (state == ST_WALK);

  always_comb begin
    cmd = '0;
    if (state == ST_IDLE) begin
      if (ackReq) begin
        if (pendInRange && (pendPrio < runPrio)) cmd.ackTake = 1'b1;
        else                                     cmd.ackSpur = 1'b1;
      end else if (eoiReq && eoiInRange && (runId != NO_IRQ)) begin
        cmd.repend = stillRaised;
        if (eoiId == runId) cmd.eoiTop    = 1'b1;
        else                cmd.walkStart = 1'b1;
      end
    end else begin
      if (walkLink == walkTgt)                              cmd.walkSplice  = 1'b1;
      else if ((walkLink != NO_IRQ) && (stepCnt != LAST_STEP)) cmd.walkAdvance = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else if (state == ST_IDLE) begin
      stepCnt <= '0;
      if (cmd.walkStart) state <= ST_WALK;
    end else begin
      if (cmd.walkAdvance) stepCnt <= stepCnt + 1'b1;
      else                 state   <= ST_IDLE;
    end
  end
endmodule

// File: rtl/irq_track_dp.sv
module irq_track_dp
  import irq_track_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  trk_cmd_t                   cmd,
  input  logic [ID_W-1:0]            eoiId,
  input  logic [ID_W-1:0]            pendId,
  input  logic [NUM_IRQ*PRIO_W-1:0]  prioTable,
  output logic [PRIO_W:0]            pendPrio,
  output logic [ID_W-1:0]            walkLink,
  output logic [ID_W-1:0]            walkTgt,
  output logic [ID_W-1:0]            ackId,
  output logic                       ackValid,
  output logic [ID_W-1:0]            runId,
  output logic [PRIO_W:0]            runPrio,
  output logic                       clrPendValid,
  output logic [ID_W-1:0]            clrPendId,
  output logic                       setPendValid,
  output logic [ID_W-1:0]            setPendId
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic [ID_W-1:0] linkTab [NUM_IRQ];
  logic [ID_W-1:0] walkCur;
  logic [ID_W-1:0] topLink;
  logic [PRIO_W:0] topPrio;

  function automatic logic [PRIO_W:0] prioOf(input logic [ID_W-1:0] id);
    return {1'b0, prioTable[id[IDX_W-1:0]*PRIO_W +: PRIO_W]};
  endfunction

  assign pendPrio = prioOf(pendId);
  assign walkLink = linkTab[walkCur[IDX_W-1:0]];
  assign topLink  = linkTab[runId[IDX_W-1:0]];
  assign topPrio  = (topLink == NO_IRQ) ? IDLE_PRIO : prioOf(topLink);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IRQ; i++) linkTab[i] <= NO_IRQ;
      runId        <= NO_IRQ;
      runPrio      <= IDLE_PRIO;
      ackId        <= NO_IRQ;
      ackValid     <= 1'b0;
      clrPendValid <= 1'b0;
      clrPendId    <= NO_IRQ;
      setPendValid <= 1'b0;
      setPendId    <= NO_IRQ;
      walkCur      <= NO_IRQ;
      walkTgt      <= NO_IRQ;
    end else begin
      ackValid     <= cmd.ackTake | cmd.ackSpur;
      clrPendValid <= cmd.ackTake;
      setPendValid <= cmd.repend;
      if (cmd.ackSpur) ackId <= NO_IRQ;
      if (cmd.ackTake) begin
        ackId                        <= pendId;
        clrPendId                    <= pendId;
        linkTab[pendId[IDX_W-1:0]]   <= runId;
        runId                        <= pendId;
        runPrio                      <= pendPrio;
      end
      if (cmd.repend) setPendId <= eoiId;
      if (cmd.eoiTop) begin
        runId   <= topLink;
        runPrio <= topPrio;
      end
      if (cmd.walkStart) begin
        walkCur <= runId;
        walkTgt <= eoiId;
      end
      if (cmd.walkAdvance) walkCur <= walkLink;
      if (cmd.walkSplice)
        linkTab[walkCur[IDX_W-1:0]] <= linkTab[walkTgt[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/irq_track_top.sv
module irq_track_top
  import irq_track_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ackReq,
  input  logic                       eoiReq,
  input  logic [9:0]                 eoiId,
  input  logic [9:0]                 pendId,
  input  logic [NUM_IRQ*PRIO_W-1:0]  prioTable,
  input  logic [NUM_IRQ-1:0]         edgeCfg,
  input  logic [NUM_IRQ-1:0]         enableVec,
  input  logic [NUM_IRQ-1:0]         levelVec,
  input  logic [NUM_IRQ-1:0]         targetVec,
  output logic [9:0]                 ackId,
  output logic                       ackValid,
  output logic [9:0]                 runId,
  output logic [PRIO_W:0]            runPrio,
  output logic                       clrPendValid,
  output logic [9:0]                 clrPendId,
  output logic                       setPendValid,
  output logic [9:0]                 setPendId,
  output logic                       busy
);
  trk_cmd_t        cmd;
  logic [PRIO_W:0] pendPrio;
  logic [ID_W-1:0] walkLink, walkTgt;

  irq_track_ctrl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ackReq(ackReq), .eoiReq(eoiReq),
    .eoiId(eoiId), .pendId(pendId), .runId(runId), .runPrio(runPrio),
    .pendPrio(pendPrio), .walkLink(walkLink), .walkTgt(walkTgt),
    .edgeCfg(edgeCfg), .enableVec(enableVec), .levelVec(levelVec),
    .targetVec(targetVec), .cmd(cmd), .busy(busy)
  );

  irq_track_dp #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .eoiId(eoiId), .pendId(pendId),
    .prioTable(prioTable), .pendPrio(pendPrio), .walkLink(walkLink),
    .walkTgt(walkTgt), .ackId(ackId), .ackValid(ackValid), .runId(runId),
    .runPrio(runPrio), .clrPendValid(clrPendValid), .clrPendId(clrPendId),
    .setPendValid(setPendValid), .setPendId(setPendId)
  );
endmodule

// File: rtl/irq_track_checker.sv
module irq_track_checker #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             eoiReq,
  input logic [9:0]       eoiId,
  input logic [9:0]       ackId,
  input logic             ackValid,
  input logic [9:0]       runId,
  input logic [PRIO_W:0]  runPrio,
  input logic             clrPendValid,
  input logic [9:0]       clrPendId,
  input logic             setPendValid,
  input logic             busy
);
  localparam logic [9:0] NUM_ID = 10'(NUM_IRQ);

  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    (runId == 10'h3FF) |-> (runPrio == {1'b1, {PRIO_W{1'b0}}})); // R4
  AST_CLEAR_MATCHES_ACK: assert property (@(posedge clk) disable iff (!rstN)
    clrPendValid |-> (ackValid && clrPendId == ackId && ackId != 10'h3FF)); // R2
  AST_TAKEN_IS_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackId != 10'h3FF) |-> (runId == ackId)); // R2
  AST_BUSY_BLOCKS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !ackValid); // R10
  AST_WALK_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(runId)); // R8
  AST_OUT_OF_RANGE_EOI: assert property (@(posedge clk) disable iff (!rstN)
    (eoiReq && !busy && eoiId >= NUM_ID) |=> (!busy && !setPendValid)); // R5
endmodule

bind irq_track_top irq_track_checker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) chk_i (
  .clk(clk), .rstN(rstN), .eoiReq(eoiReq), .eoiId(eoiId), .ackId(ackId),
  .ackValid(ackValid), .runId(runId), .runPrio(runPrio),
  .clrPendValid(clrPendValid), .clrPendId(clrPendId),
  .setPendValid(setPendValid), .busy(busy)
);

// File: tb/irq_track_tb.sv
`timescale 1ns/1ps
module irq_track_top_tb_top;
  localparam int NUM = 64;
  localparam int PW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ackReq = 1'b0, eoiReq = 1'b0;
  logic [9:0] eoiId = '0, pendId = 10'h3FF;
  logic [NUM*PW-1:0] prioTable;
  logic [NUM-1:0] edgeCfg = '0, enableVec = '0, levelVec = '0, targetVec = '0;
  logic [9:0] ackId, runId, clrPendId, setPendId;
  logic ackValid, clrPendValid, setPendValid, busy;
  logic [PW:0] runPrio;

  int prioM [NUM];
  int checks = 0, errors = 0;
  bit checking = 0;

  always #4 clk = ~clk;  // 125 MHz

  always_comb
    for (int i = 0; i < NUM; i++) prioTable[i*PW +: PW] = PW'(prioM[i]);

  irq_track_top #(.NUM_IRQ(NUM), .PRIO_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .ackReq(ackReq), .eoiReq(eoiReq), .eoiId(eoiId),
    .pendId(pendId), .prioTable(prioTable), .edgeCfg(edgeCfg),
    .enableVec(enableVec), .levelVec(levelVec), .targetVec(targetVec),
    .ackId(ackId), .ackValid(ackValid), .runId(runId), .runPrio(runPrio),
    .clrPendValid(clrPendValid), .clrPendId(clrPendId),
    .setPendValid(setPendValid), .setPendId(setPendId), .busy(busy)
  );

  // behavioural reference model
  int mLink [1024];
  int mRun, mPrio, mAckId, mClrId, mSetId, mBusyCnt;
  bit mAckV, mClrV, mSetV;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mLink[i]) mLink[i] = 1023;
      mRun = 1023; mPrio = 256; mAckId = 1023; mBusyCnt = 0;
      mAckV = 0; mClrV = 0; mSetV = 0;
    end else begin
      mAckV = 0; mClrV = 0; mSetV = 0;
      if (mBusyCnt > 0) mBusyCnt--;
      else if (ackReq) begin
        mAckV = 1;
        if (int'(pendId) < NUM && prioM[pendId] < mPrio) begin
          mLink[pendId] = mRun; mRun = pendId; mPrio = prioM[pendId];
          mAckId = pendId; mClrV = 1; mClrId = pendId;
        end else mAckId = 1023;
      end else if (eoiReq && int'(eoiId) < NUM && mRun != 1023) begin
        if (!edgeCfg[eoiId] && enableVec[eoiId] && levelVec[eoiId] && targetVec[eoiId]) begin
          mSetV = 1; mSetId = eoiId;
        end
        if (int'(eoiId) == mRun) begin
          mRun = mLink[mRun]; mPrio = (mRun == 1023) ? 256 : prioM[mRun];
        end else begin
          int cur, k;
          cur = mRun; k = 0;
          while (1) begin
            k++;
            if (mLink[cur] == int'(eoiId)) begin mLink[cur] = mLink[eoiId]; break; end
            if (mLink[cur] == 1023 || k == NUM) break;
            cur = mLink[cur];
          end
          mBusyCnt = k;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) if (checking) begin
    chk("R7", "model runId", int'(runId), mRun);
    chk("R4", "model runPrio", int'(runPrio), mPrio);
    chk("R8", "model busy", int'(busy), int'(mBusyCnt > 0));
    chk("R3", "model ackValid", int'(ackValid), int'(mAckV));
    chk("R2", "model ackId", int'(ackId), mAckId);
    chk("R2", "model clrPendValid", int'(clrPendValid), int'(mClrV));
    if (mClrV) chk("R2", "model clrPendId", int'(clrPendId), mClrId);
    chk("R9", "model setPendValid", int'(setPendValid), int'(mSetV));
    if (mSetV) chk("R9", "model setPendId", int'(setPendId), mSetId);
  end

  task automatic strobe(input bit a, input bit e, input int pid, input int eid);
    ackReq = a; eoiReq = e; pendId = 10'(pid); eoiId = 10'(eid);
    @(negedge clk);
    ackReq = 0; eoiReq = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM; i++) prioM[i] = 8'hA0 + (i % 16);
    prioM[5] = 8'h00; prioM[10] = 8'h80; prioM[11] = 8'h80; prioM[20] = 8'h40;
    prioM[30] = 8'h20; prioM[40] = 8'h60; prioM[41] = 8'h60; prioM[55] = 8'h70;
    edgeCfg[41] = 1'b1;
    enableVec[5] = 1; levelVec[5] = 1; targetVec[5] = 1;
    enableVec[40] = 1; levelVec[40] = 1; targetVec[40] = 1;
    enableVec[41] = 1; levelVec[41] = 1; targetVec[41] = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checking = 1;
    @(negedge clk);
    chk("R1", "reset runId", runId, 1023);
    chk("R1", "reset runPrio", runPrio, 256);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset pulses", {ackValid, clrPendValid, setPendValid}, 0);

    strobe(1, 0, 1023, 0);
    chk("R3", "ack of 1023", ackId, 1023);
    chk("R3", "no clear on spurious", clrPendValid, 0);
    strobe(0, 1, 0, 5);
    chk("R6", "eoi while idle runId", runId, 1023);
    chk("R6", "eoi while idle no repend", setPendValid, 0);

    strobe(1, 0, 10, 0);
    chk("R2", "ack 10 id", ackId, 10);
    chk("R2", "ack 10 clear", clrPendId, 10);
    chk("R4", "prio after ack 10", runPrio, 8'h80);
    strobe(1, 0, 11, 0);
    chk("R3", "equal prio refused", ackId, 1023);
    chk("R3", "equal prio keeps run", runId, 10);
    strobe(1, 0, 20, 0);
    strobe(1, 0, 30, 0);
    chk("R2", "nested run", runId, 30);

    strobe(0, 1, 0, 10);
    chk("R8", "walk busy", busy, 1);
    strobe(1, 0, 5, 0);
    chk("R10", "ack ignored while busy", ackValid, 0);
    chk("R10", "run kept while busy", runId, 30);
    @(negedge clk);
    chk("R8", "walk of two entries done", busy, 0);

    strobe(0, 1, 0, 70);
    chk("R5", "eoi 70 ignored", runId, 30);
    chk("R5", "eoi 70 no busy", busy, 0);
    strobe(0, 1, 0, 1023);
    chk("R5", "eoi 1023 ignored", runId, 30);

    strobe(0, 1, 0, 30);
    chk("R7", "pop to 20", runId, 20);
    chk("R7", "prio of 20", runPrio, 8'h40);
    chk("R7", "pop no busy", busy, 0);
    strobe(0, 1, 0, 20);
    chk("R8", "spliced link leaves idle", runId, 1023);
    chk("R4", "idle prio", runPrio, 256);

    strobe(1, 0, 40, 0);
    strobe(0, 1, 0, 40);
    chk("R9", "level repend", setPendValid, 1);
    chk("R9", "level repend id", setPendId, 40);
    strobe(1, 0, 41, 0);
    strobe(0, 1, 0, 41);
    chk("R9", "edge no repend", setPendValid, 0);

    strobe(1, 1, 10, 10);
    chk("R11", "ack wins", runId, 10);
    chk("R11", "ack reported", ackValid, 1);
    strobe(1, 0, 20, 0);
    strobe(0, 1, 0, 55);
    chk("R8", "absent walk busy", busy, 1);
    @(negedge clk);
    @(negedge clk);
    chk("R8", "absent walk ends", busy, 0);
    chk("R8", "absent walk keeps run", runId, 20);
    strobe(0, 1, 0, 20);
    strobe(0, 1, 0, 10);
    chk("R7", "back to idle", runId, 1023);

    for (int i = 0; i < NUM; i++) prioM[i] = int'($urandom_range(255));
    edgeCfg = {$urandom, $urandom}; enableVec = {$urandom, $urandom};
    levelVec = {$urandom, $urandom}; targetVec = {$urandom, $urandom};
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom);
      ackReq = (r % 4) == 0;
      eoiReq = ((r >> 2) % 3) == 0;
      pendId = ((r >> 4) % 8 == 0) ? 10'h3FF : 10'(((r >> 8) & 255) % NUM);
      eoiId  = ((r >> 7) % 8 == 0) ? ((r[20]) ? 10'h3FF : 10'd70)
                                   : 10'(((r >> 16) & 255) % NUM);
      @(negedge clk);
    end
    ackReq = 0; eoiReq = 0;
    repeat (NUM + 2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule